// File: doc/BRIEF.md
# Sampled Interrupt Polling Arbiter

This block works next to a simple CPU sequencer and decides when a hardware-generated long call to an interrupt service routine may begin. The request flags are captured once per machine cycle, at a strobe late in that cycle. The poll in the following machine cycle judges only that captured copy. The poll keeps the requests whose source and the global switch are both enabled. It picks the one at the highest priority level, and the lowest source index breaks a tie. A call is issued only if nothing blocks it.

A call is blocked in four cases. The first is a poll cycle that is not the last cycle of the running instruction. The second is an instruction that is a return-from-interrupt or that writes an interrupt enable or priority register. The third is the instruction after such an instruction. The fourth is a service routine already running at the same or a higher level. A blocked request is simply dropped. It is serviced later only if it appears again in a later capture. The block keeps one in-service bit per priority level. An issued call sets the bit of its level, and a return-from-interrupt clears the highest bit that is set.

An issued call is a one-clock pulse carrying the source index and a vector address equal to a fixed base plus eight times that index.

Top module: `irqPollArbiter`

## Requirements
- R1: The poll at a strobe edge uses only the flags captured at the previous strobe edge; flag values present at the current strobe go into the next capture, and values between strobes are never seen.
- R2: An issued call appears as `callReq` high for the one clock that follows the strobe edge, with `callIdx` the winning source and `callVec` = VEC_BASE + 8 * `callIdx` (VEC_BASE defaults to 3).
- R3: Priority of source i is `prio[2i+1:2i]`, 3 highest and 0 lowest; the highest level among candidates wins, and among equal levels the lowest index wins.
- R4: A request is a candidate only if `globalEn` is 1 and its bit in `srcEn` is 1 at the poll; otherwise it is ignored.
- R5: No call is issued at a strobe where `lastCycle` is 0.
- R6: No call is issued at a strobe where `retiNow` or `ctlWrNow` is 1, nor at the final-cycle strobe of the instruction that follows one that ended with either of them high.
- R7: No call is issued while the in-service bit of the winner's level or of any higher level is set.
- R8: An issued call sets the in-service bit of its level; a final-cycle strobe with `retiNow` high clears only the highest set in-service bit.
- R9: A request that is blocked is not remembered: it is served only if it is present in a later capture.
- R10: After reset no call is issued, the capture is empty and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqFlags | input | NUM_SRC | Live interrupt request flags |
| srcEn | input | NUM_SRC | Per-source enable |
| globalEn | input | 1 | Global interrupt enable |
| prio | input | 2*NUM_SRC | Two-bit priority level per source |
| sampleStb | input | 1 | Capture/poll strobe, once per machine cycle |
| lastCycle | input | 1 | Current machine cycle is the instruction's final cycle |
| retiNow | input | 1 | Running instruction is a return-from-interrupt |
| ctlWrNow | input | 1 | Running instruction writes an enable or priority register |
| callReq | output | 1 | One-clock call request pulse |
| callIdx | output | IDX_W | Winning source index |
| callVec | output | VEC_W | Service routine vector address |

## Verification
The bench targets several corner cases and the bug each one would expose. A flag raised at the same strobe as the poll must not be answered at once; a design that polled the live flags would answer one machine cycle early. A tie between two sources at level 3 must go to the lower index. After a register write, the next instruction's final poll must still be held off; a design without the guard flag would vector one instruction early. After a nested return, the lower level must stay in service; a design that cleared every in-service bit would re-enter the level-1 routine before it finished. A behavioural model with its own integer bookkeeping is compared on every clock under random flags, strobes, returns and writes.

// File: rtl/irqPollPkg.sv
package irqPollPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the request flags
    logic issue;    // launch the call for the current winner
  } pollStrb_t;
endpackage

// File: rtl/irqPollData.sv
module irqPollData
  import irqPollPkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int LEVELS   = 4,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int LVL_W   = $clog2(LEVELS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pollStrb_t                strb,
  input  logic [NUM_SRC-1:0]       reqFlags,
  input  logic [NUM_SRC-1:0]       srcEn,
  input  logic                     globalEn,
  input  logic [NUM_SRC*LVL_W-1:0] prio,
  output logic                     winValid,
  output logic [LVL_W-1:0]         winLvl,
  output logic                     callReq,
  output logic [IDX_W-1:0]         callIdx,
  output logic [VEC_W-1:0]         callVec
);
  logic [NUM_SRC-1:0] snapReg;
  logic [NUM_SRC-1:0] cand;
  logic [IDX_W-1:0]   winIdx;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_cand
      assign cand[g] = snapReg[g] & srcEn[g] & globalEn;
    end
  endgenerate

  // descending scan with >= so the lowest index wins a tie
  always_comb begin
    winValid = 1'b0;
    winLvl   = '0;
    winIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!winValid || prio[i*LVL_W +: LVL_W] >= winLvl)) begin
        winValid = 1'b1;
        winLvl   = prio[i*LVL_W +: LVL_W];
        winIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapReg <= '0;
      callReq <= 1'b0;
      callIdx <= '0;
    end else begin
      if (strb.capture) snapReg <= reqFlags;
      callReq <= strb.issue;
      if (strb.issue) callIdx <= winIdx;
    end
  end

  assign callVec = VEC_W'(VEC_BASE) + (VEC_W'(callIdx) << 3);

  // R1
  snap_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> ((($past(snapReg)) >> callIdx) & NUM_SRC'(1)) != '0);
  // R4
  enabled_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(globalEn) && ((($past(srcEn)) >> callIdx) & NUM_SRC'(1)) != '0);
endmodule

// File: rtl/irqPollCtrl.sv
module irqPollCtrl
  import irqPollPkg::*;
#(
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic             lastCycle,
  input  logic             retiNow,
  input  logic             ctlWrNow,
  input  logic             winValid,
  input  logic [LVL_W-1:0] winLvl,
  output pollStrb_t        strb
);
  logic [LEVELS-1:0] inSvc;
  logic [LEVELS-1:0] topMask;
  logic              guard;
  logic              evtNow;
  logic              svcBlock;
  logic              retire;

  assign evtNow   = retiNow | ctlWrNow;
  assign svcBlock = (inSvc >> winLvl) != '0;
  assign retire   = sampleStb & lastCycle & retiNow;

  assign strb.capture = sampleStb;
  assign strb.issue   = sampleStb & lastCycle & ~evtNow & ~guard & winValid & ~svcBlock;

  always_comb begin
    topMask = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (inSvc[k]) topMask = LEVELS'(1) << k;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvc <= '0;
      guard <= 1'b0;
    end else begin
      if (strb.issue)  inSvc <= inSvc | (LEVELS'(1) << winLvl);
      else if (retire) inSvc <= inSvc & ~topMask;
      if (sampleStb && lastCycle) guard <= evtNow;
    end
  end

  // R5
  final_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> lastCycle);
  // R6
  no_event_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> !retiNow && !ctlWrNow);
  // R6
  guard_after_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && lastCycle && evtNow) |=> !strb.issue);
  // R8
  svc_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> $countones(inSvc) == $past($countones(inSvc)) + 1);
  // R8
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retire && inSvc != '0) |=> $countones(inSvc) == $past($countones(inSvc)) - 1);
endmodule

// File: rtl/irqPollArbiter.sv
module irqPollArbiter
  import irqPollPkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int LEVELS   = 4,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int LVL_W   = $clog2(LEVELS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       reqFlags,
  input  logic [NUM_SRC-1:0]       srcEn,
  input  logic                     globalEn,
  input  logic [NUM_SRC*LVL_W-1:0] prio,
  input  logic                     sampleStb,
  input  logic                     lastCycle,
  input  logic                     retiNow,
  input  logic                     ctlWrNow,
  output logic                     callReq,
  output logic [IDX_W-1:0]         callIdx,
  output logic [VEC_W-1:0]         callVec
);
  pollStrb_t        strb;
  logic             winValid;
  logic [LVL_W-1:0] winLvl;

  irqPollCtrl #(.LEVELS(LEVELS)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lastCycle(lastCycle),
    .retiNow(retiNow), .ctlWrNow(ctlWrNow), .winValid(winValid),
    .winLvl(winLvl), .strb(strb)
  );

  irqPollData #(.NUM_SRC(NUM_SRC), .LEVELS(LEVELS), .VEC_W(VEC_W),
                .VEC_BASE(VEC_BASE)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .reqFlags(reqFlags), .srcEn(srcEn),
    .globalEn(globalEn), .prio(prio), .winValid(winValid), .winLvl(winLvl),
    .callReq(callReq), .callIdx(callIdx), .callVec(callVec)
  );

  // R2
  pulse_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(sampleStb));
endmodule

// File: tb/tb_irqPollArbiter.sv
`timescale 1ns/1ps
module tb_irqPollArbiter;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  reqFlags = 0, srcEn = 8'hFF;
  logic        globalEn = 1;
  logic [15:0] prio = 0;
  logic        sampleStb = 0, lastCycle = 0, retiNow = 0, ctlWrNow = 0;
  logic        callReq;
  logic [2:0]  callIdx;
  logic [15:0] callVec;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R10";
  logic obsReq; logic [2:0] obsIdx; logic [15:0] obsVec;

  // behavioural reference state
  int mSnap[8];
  int mSvc[4];
  int mGuard;
  int expReq, expIdx;

  irqPollArbiter dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mSnap[i]) mSnap[i] = 0;
      foreach (mSvc[i]) mSvc[i] = 0;
      mGuard = 0; expReq = 0; expIdx = 0;
    end else begin
      expReq = 0;
      if (sampleStb) begin
        int bestI, bestL, blk;
        bestI = -1; bestL = -1;
        for (int i = 0; i < 8; i++) begin
          int l;
          l = prio[2*i +: 2];
          if (mSnap[i] != 0 && srcEn[i] && globalEn && l > bestL) begin
            bestL = l; bestI = i;
          end
        end
        blk = (!lastCycle || retiNow || ctlWrNow || mGuard != 0) ? 1 : 0;
        for (int k = 0; k < 4; k++) if (bestI >= 0 && k >= bestL && mSvc[k] != 0) blk = 1;
        if (bestI >= 0 && blk == 0) begin
          expReq = 1; expIdx = bestI; mSvc[bestL] = 1;
        end
        if (lastCycle && retiNow) begin
          int top;
          top = -1;
          for (int k = 0; k < 4; k++) if (mSvc[k] != 0) top = k;
          if (top >= 0) mSvc[top] = 0;
        end
        if (lastCycle) mGuard = (retiNow || ctlWrNow) ? 1 : 0;
        for (int i = 0; i < 8; i++) mSnap[i] = reqFlags[i];
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (callReq !== expReq[0] ||
          (expReq != 0 && (callIdx !== 3'(expIdx) || callVec !== 16'(3 + 8*expIdx)))) begin
        fails++;
        $display("FAIL %s cycle %0d: req=%0d idx=%0d vec=%0d expected req=%0d idx=%0d vec=%0d",
                 tag, cyc, callReq, callIdx, callVec, expReq, expIdx, 3 + 8*expIdx);
      end
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        report();
      end
    end
  end

  task automatic mcycle(input logic [7:0] f, input logic last, input logic reti, input logic wr);
    reqFlags = f; lastCycle = last; retiNow = reti; ctlWrNow = wr; sampleStb = 1;
    @(posedge clk); @(negedge clk);
    obsReq = callReq; obsIdx = callIdx; obsVec = callVec;
    sampleStb = 0; retiNow = 0; ctlWrNow = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expectCall(input logic v, input int idx, input string t);
    checks++;
    if (obsReq !== v || (v && (obsIdx !== 3'(idx) || obsVec !== 16'(3 + 8*idx)))) begin
      fails++;
      $display("FAIL %s: req=%0d idx=%0d vec=%0d expected req=%0d idx=%0d vec=%0d",
               t, obsReq, obsIdx, obsVec, v, idx, 3 + 8*idx);
    end
  endtask

  task automatic cleanup();
    mcycle(8'h00, 1, 1, 0);
    mcycle(8'h00, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: nothing issued in reset
    obsReq = callReq; obsIdx = 0; obsVec = callVec;
    expectCall(0, 0, "R10 reset");
    rstN = 1;
    @(negedge clk);

    tag = "R1";
    mcycle(8'h04, 1, 0, 0); expectCall(0, 0, "R1 live flag not polled");
    tag = "R2";
    mcycle(8'h00, 1, 0, 0); expectCall(1, 2, "R2 call from capture");
    cleanup();

    tag = "R3";
    prio[2*1 +: 2] = 2'd1; prio[2*5 +: 2] = 2'd3; prio[2*6 +: 2] = 2'd3;
    mcycle(8'h62, 1, 0, 0); mcycle(8'h00, 1, 0, 0);
    expectCall(1, 5, "R3 highest level lowest index");
    cleanup();

    tag = "R4";
    srcEn[5] = 0;
    mcycle(8'h62, 1, 0, 0); mcycle(8'h00, 1, 0, 0);
    expectCall(1, 6, "R4 disabled source skipped");
    cleanup();
    srcEn[5] = 1; globalEn = 0;
    mcycle(8'h62, 1, 0, 0); mcycle(8'h00, 1, 0, 0);
    expectCall(0, 0, "R4 global disable");
    globalEn = 1;

    tag = "R5";
    mcycle(8'h01, 1, 0, 0); mcycle(8'h00, 0, 0, 0);
    expectCall(0, 0, "R5 not final cycle");
    tag = "R9";
    mcycle(8'h00, 1, 0, 0); expectCall(0, 0, "R9 dropped request forgotten");
    mcycle(8'h01, 1, 0, 0); mcycle(8'h01, 0, 0, 0);
    mcycle(8'h00, 1, 0, 0); expectCall(1, 0, "R9 re-captured request served");
    cleanup();

    tag = "R6";
    mcycle(8'h01, 1, 0, 0); mcycle(8'h01, 1, 0, 1);
    expectCall(0, 0, "R6 write instruction");
    mcycle(8'h01, 1, 0, 0); expectCall(0, 0, "R6 next instruction held");
    mcycle(8'h00, 1, 0, 0); expectCall(1, 0, "R6 released after guard");
    cleanup();

    tag = "R7";
    mcycle(8'h02, 1, 0, 0); mcycle(8'h00, 1, 0, 0); expectCall(1, 1, "R7 level1 entry");
    mcycle(8'h02, 1, 0, 0); mcycle(8'h00, 1, 0, 0); expectCall(0, 0, "R7 equal level blocked");
    mcycle(8'h20, 1, 0, 0); mcycle(8'h00, 1, 0, 0); expectCall(1, 5, "R7 higher level nests");
    tag = "R8";
    mcycle(8'h02, 1, 0, 0); mcycle(8'h00, 1, 1, 0); expectCall(0, 0, "R8 return blocks");
    mcycle(8'h02, 1, 0, 0); expectCall(0, 0, "R8 guard after return");
    mcycle(8'h00, 1, 0, 0); expectCall(0, 0, "R8 level1 still in service");
    mcycle(8'h00, 1, 1, 0); mcycle(8'h02, 1, 0, 0);
    mcycle(8'h00, 1, 0, 0); expectCall(1, 1, "R8 level1 freed by second return");
    cleanup();

    tag = "R3 random";
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 16) == 0) begin
        prio = 16'($urandom); srcEn = 8'($urandom | 8'h11); globalEn = ($urandom % 8) != 0;
      end
      mcycle(8'($urandom & $urandom), ($urandom % 4) != 0, ($urandom % 8) == 0,
             ($urandom % 10) == 0);
    end
    report();
  end
endmodule